// File: doc/BRIEF.md
# Super Block Framer with Marker and Parity Slots

This block arranges one lane of 16-bit link characters into fixed-size super blocks. A super block is four character blocks. Each character block is 510 characters long, and its final 8 positions are parity slots. The first position of every super block holds an unscrambled marker character. The marker is either an alignment marker or, once per cycle of 33 super blocks, a scrambler-reset marker. Every other position carries payload that is XORed with a 16-bit LFSR keystream.

The framer sets the pace. It produces one output character on every clock and pulls payload from an upstream packet stream through a valid/ready handshake. The upstream source marks the first character of each packet and gives the packet's full length with it. A packet may run on from one character block into the next. A packet may never cross into the next super block: if a new packet would not fit in the payload slots left in the current super block, the framer holds it back and sends gap characters until the next super block begins. The framer also sends a gap character whenever no payload is offered.

The framer shows its current slot position (block number, index within the block, parity flag) as outputs. An external parity generator uses these to present the right parity character on the cycle a parity slot is taken. Markers leave the block as 16-bit placeholder values with a special flag set, and a later line coder replaces them with the real codes.

Top module: `sbf_framer`

## Requirements
- R1: While `rst` is high, `out_valid` is 0. The first character after reset is the alignment marker (16'hA55A with `out_special`=1), and `slot_block`/`slot_index` read 0/0 in the first cycle after reset.
- R2: `slot_index` counts 0 to 509 and then wraps. `slot_block` counts 0 to 3 and advances each time `slot_index` wraps, so a super block spans 2040 cycles.
- R3: Positions 502 to 509 of every character block are parity slots. `slot_parity` is 1 at these positions, and the output character is the `par_char` value sampled that cycle, unscrambled, with `out_parity`=1. A block always carries exactly 8 parity characters in a row.
- R4: Position 0 of block 0 carries a marker with `out_special`=1. That marker comes directly after the last parity slot of the previous super block, and its value is never scrambled.
- R5: Counting from reset, super blocks 0 to 31 of each 33-block cycle start with the alignment marker 16'hA55A, and super block 32 starts with the reset marker 16'h5AA5. The cycle then repeats.
- R6: A payload character leaves as data XOR S, where S is the scrambler state. After each payload slot, S advances by 16 single steps. In a single step, S shifts left by one and bit 0 becomes S[15]^S[4]^S[3]^S[2].
- R7: S is set to the lane seed 16'hFFFF by reset and on every reset-marker slot. The first payload after either event is therefore XORed with 16'hFFFF.
- R8: A payload slot with no accepted input character carries the gap character 16'h0000 XOR S, and S still advances.
- R9: A packet's first character (`in_first`=1) is accepted only in a payload slot and only when `in_len` is no larger than the payload slots left in the super block, counting the current one (2007 at the first payload slot of block 0). When a packet exactly fills the remaining slots, it is accepted.
- R10: A character inside a packet (`in_first`=0) is accepted in any payload slot, including the first payload slot after a parity run. A packet therefore continues across character block boundaries.
- R11: The output character and its flags appear one clock after the cycle in which the slot position and inputs were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream character offered |
| in_first | input | 1 | Offered character is the first of a packet |
| in_len | input | 12 | Length of the packet whose first character is offered |
| in_char | input | 16 | Offered payload character |
| in_ready | output | 1 | Framer takes the offered character this cycle |
| par_char | input | 16 | Parity character for the current parity slot |
| slot_block | output | 2 | Current character block within the super block |
| slot_index | output | 9 | Current position within the character block |
| slot_parity | output | 1 | Current position is a parity slot |
| out_valid | output | 1 | Output character is valid |
| out_char | output | 16 | Framed output character |
| out_special | output | 1 | Output is a marker code |
| out_parity | output | 1 | Output is a parity character |

## Verification
`in_ready`, `slot_block`, `slot_index` and `slot_parity` describe the present cycle. The bench samples them one time unit after it drives the inputs on the falling edge. The output character for that slot is registered on the next rising edge, one clock later. The driver pushes the expected character, flags and requirement tag into a queue as it drives each slot. The monitor pops that entry at the following falling edge, so every comparison lines up with the one-cycle latency. The packet lengths are chosen to hit the corner cases: in one super block a packet overruns the remaining payload slots by one character, and in another a packet fills them exactly.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    typedef logic [15:0] char_t;

    typedef enum logic [1:0] {
        SLOT_MARK = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_PAR  = 2'd2
    } slot_e;

    typedef struct packed {
        char_t ch;
        logic  special;
        logic  parity;
    } frame_out_t;

    // One single-bit step of the scrambler: shift left, feedback into bit 0
    function automatic char_t lfsr_step(input char_t s);
        return {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
    endfunction

    // Sixteen steps: one full advance per payload character
    function automatic char_t lfsr_adv16(input char_t s);
        char_t v;
        v = s;
        for (int i = 0; i < 16; i++) begin
            v = lfsr_step(v);
        end
        return v;
    endfunction

endpackage

// File: rtl/sbf_position.sv
module sbf_position
    import sbf_pkg::*;
#(
    parameter int BLK_CHARS = 510,
    parameter int PAR_SLOTS = 8,
    parameter int BLKS      = 4,
    parameter int ALIGN_RUN = 32,
    parameter int LEN_W     = 12,
    parameter int IDX_W     = $clog2(BLK_CHARS),
    parameter int BLK_W     = (BLKS > 1) ? $clog2(BLKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx,
    output logic [BLK_W-1:0] blk,
    output slot_e            kind,
    output logic             reset_sb,
    output logic [LEN_W-1:0] pay_left
);
    localparam int DATA_N  = BLK_CHARS - PAR_SLOTS;
    localparam int SB_PAY  = BLKS * DATA_N - 1;
    localparam int SB_W    = $clog2(ALIGN_RUN + 1);

    logic [SB_W-1:0] sb_no;
    logic            last_idx;
    logic            last_blk;

    assign last_idx = (idx == IDX_W'(BLK_CHARS - 1));
    assign last_blk = (blk == BLK_W'(BLKS - 1));
    assign reset_sb = (sb_no == SB_W'(ALIGN_RUN));

    always_comb begin
        if (blk == '0 && idx == '0) begin
            kind = SLOT_MARK;
        end else if (idx >= IDX_W'(DATA_N)) begin
            kind = SLOT_PAR;
        end else begin
            kind = SLOT_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            blk   <= '0;
            sb_no <= '0;
        end else if (last_idx) begin
            idx <= '0;
            if (last_blk) begin
                blk   <= '0;
                sb_no <= reset_sb ? '0 : sb_no + 1'b1;
            end else begin
                blk <= blk + 1'b1;
            end
        end else begin
            idx <= idx + 1'b1;
        end
    end

    // Payload slots still open in this super block, current one included
    always_ff @(posedge clk) begin
        if (rst) begin
            pay_left <= LEN_W'(SB_PAY);
        end else if (kind == SLOT_MARK) begin
            pay_left <= LEN_W'(SB_PAY);
        end else if (kind == SLOT_DATA) begin
            pay_left <= pay_left - 1'b1;
        end
    end

endmodule

// File: rtl/sbf_scrambler.sv
module sbf_scrambler
    import sbf_pkg::*;
#(
    parameter char_t LANE_SEED = 16'hFFFF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  reseed,
    input  logic  step,
    output char_t ks
);
    char_t state;

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            state <= LANE_SEED;
        end else if (step) begin
            state <= lfsr_adv16(state);
        end
    end

    assign ks = state;

endmodule

// File: rtl/sbf_admit.sv
module sbf_admit
    import sbf_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  slot_e            kind,
    input  logic             in_first,
    input  logic [LEN_W-1:0] in_len,
    input  logic [LEN_W-1:0] pay_left,
    output logic             ready
);
    logic fits;

    assign fits  = (in_len <= pay_left);
    assign ready = (kind == SLOT_DATA) && (!in_first || fits);

endmodule

// File: rtl/sbf_framer.sv
module sbf_framer
    import sbf_pkg::*;
#(
    parameter int    BLK_CHARS  = 510,
    parameter int    PAR_SLOTS  = 8,
    parameter int    BLKS       = 4,
    parameter int    ALIGN_RUN  = 32,
    parameter int    LEN_W      = 12,
    parameter char_t LANE_SEED  = 16'hFFFF,
    parameter char_t ALIGN_CODE = 16'hA55A,
    parameter char_t RESET_CODE = 16'h5AA5,
    parameter char_t GAP_CODE   = 16'h0000,
    parameter int    IDX_W      = $clog2(BLK_CHARS),
    parameter int    BLK_W      = (BLKS > 1) ? $clog2(BLKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [LEN_W-1:0] in_len,
    input  logic [15:0]      in_char,
    output logic             in_ready,
    input  logic [15:0]      par_char,
    output logic [BLK_W-1:0] slot_block,
    output logic [IDX_W-1:0] slot_index,
    output logic             slot_parity,
    output logic             out_valid,
    output logic [15:0]      out_char,
    output logic             out_special,
    output logic             out_parity
);
    slot_e            kind;
    logic             reset_sb;
    logic [LEN_W-1:0] pay_left;
    char_t            ks;
    logic             take;
    frame_out_t       nxt;
    frame_out_t       cur;

    sbf_position #(
        .BLK_CHARS (BLK_CHARS),
        .PAR_SLOTS (PAR_SLOTS),
        .BLKS      (BLKS),
        .ALIGN_RUN (ALIGN_RUN),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W),
        .BLK_W     (BLK_W)
    ) u_pos (
        .clk      (clk),
        .rst      (rst),
        .idx      (slot_index),
        .blk      (slot_block),
        .kind     (kind),
        .reset_sb (reset_sb),
        .pay_left (pay_left)
    );

    sbf_scrambler #(
        .LANE_SEED (LANE_SEED)
    ) u_scr (
        .clk    (clk),
        .rst    (rst),
        .reseed ((kind == SLOT_MARK) && reset_sb),
        .step   (kind == SLOT_DATA),
        .ks     (ks)
    );

    sbf_admit #(
        .LEN_W (LEN_W)
    ) u_adm (
        .kind     (kind),
        .in_first (in_first),
        .in_len   (in_len),
        .pay_left (pay_left),
        .ready    (in_ready)
    );

    assign take        = in_valid && in_ready;
    assign slot_parity = (kind == SLOT_PAR);

    always_comb begin
        nxt = '0;
        unique case (kind)
            SLOT_MARK: begin
                nxt.ch      = reset_sb ? RESET_CODE : ALIGN_CODE;
                nxt.special = 1'b1;
            end
            SLOT_PAR: begin
                nxt.ch     = par_char;
                nxt.parity = 1'b1;
            end
            default: begin
                nxt.ch = (take ? in_char : GAP_CODE) ^ ks;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            out_valid <= 1'b0;
        end else begin
            cur       <= nxt;
            out_valid <= 1'b1;
        end
    end

    assign out_char    = cur.ch;
    assign out_special = cur.special;
    assign out_parity  = cur.parity;

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
    parameter int          BLK_CHARS  = 510,
    parameter int          PAR_SLOTS  = 8,
    parameter logic [15:0] ALIGN_CODE = 16'hA55A,
    parameter logic [15:0] RESET_CODE = 16'h5AA5,
    parameter int          IDX_W      = 9,
    parameter int          BLK_W      = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic [15:0]      par_char,
    input logic [BLK_W-1:0] slot_block,
    input logic [IDX_W-1:0] slot_index,
    input logic             slot_parity,
    input logic             out_valid,
    input logic [15:0]      out_char,
    input logic             out_special,
    input logic             out_parity
);
    localparam int RUN_W = $clog2(PAR_SLOTS + 2);

    logic [RUN_W-1:0] prun;

    always_ff @(posedge clk) begin
        if (rst) begin
            prun <= '0;
        end else if (out_parity) begin
            prun <= prun + 1'b1;
        end else begin
            prun <= '0;
        end
    end

    a_r2_index_steps: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(slot_index) != IDX_W'(BLK_CHARS - 1))
        |-> slot_index == $past(slot_index) + 1'b1);

    a_r3_parity_run: assert property (@(posedge clk) disable iff (rst)
        (!out_parity && $past(out_parity)) |-> prun == RUN_W'(PAR_SLOTS));

    a_r3_parity_max: assert property (@(posedge clk) disable iff (rst)
        prun <= RUN_W'(PAR_SLOTS));

    a_r3_parity_passthru: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_parity) |-> out_char == $past(par_char));

    a_r4_marker_after_parity: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_special && $past(out_valid)) |-> $past(out_parity));

    a_r4_marker_code: assert property (@(posedge clk) disable iff (rst)
        out_special |-> (out_char == ALIGN_CODE || out_char == RESET_CODE));

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_special, out_parity}));

    a_r9_ready_in_data: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!slot_parity && !(slot_block == '0 && slot_index == '0)));

endmodule

bind sbf_framer sbf_checker #(
    .BLK_CHARS  (BLK_CHARS),
    .PAR_SLOTS  (PAR_SLOTS),
    .ALIGN_CODE (ALIGN_CODE),
    .RESET_CODE (RESET_CODE),
    .IDX_W      (IDX_W),
    .BLK_W      (BLK_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .par_char    (par_char),
    .slot_block  (slot_block),
    .slot_index  (slot_index),
    .slot_parity (slot_parity),
    .out_valid   (out_valid),
    .out_char    (out_char),
    .out_special (out_special),
    .out_parity  (out_parity)
);

// File: tb/sbf_framer_test.sv
`timescale 1ns/1ps
module sbf_framer_test;

    localparam int BLK_CHARS = 510;
    localparam int PAR_SLOTS = 8;
    localparam int BLKS      = 4;
    localparam int DATA_N    = BLK_CHARS - PAR_SLOTS;
    localparam int SB_PAY    = BLKS * DATA_N - 1;
    localparam int SB_LEN    = BLKS * BLK_CHARS;
    localparam int RUN_CYC   = 34 * SB_LEN + 8;
    localparam logic [15:0] SEED  = 16'hFFFF;
    localparam logic [15:0] ALIGN = 16'hA55A;
    localparam logic [15:0] RSTM  = 16'h5AA5;
    localparam logic [15:0] GAP   = 16'h0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_first, in_ready;
    logic [11:0] in_len;
    logic [15:0] in_char, par_char;
    logic [1:0]  slot_block;
    logic [8:0]  slot_index;
    logic        slot_parity;
    logic        out_valid, out_special, out_parity;
    logic [15:0] out_char;

    always #2.5 clk = ~clk;

    sbf_framer uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_first    (in_first),
        .in_len      (in_len),
        .in_char     (in_char),
        .in_ready    (in_ready),
        .par_char    (par_char),
        .slot_block  (slot_block),
        .slot_index  (slot_index),
        .slot_parity (slot_parity),
        .out_valid   (out_valid),
        .out_char    (out_char),
        .out_special (out_special),
        .out_parity  (out_parity)
    );

    typedef struct {
        logic [15:0] ch;
        logic        sp;
        logic        pa;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    // bench-side model state
    int          mb, mi, msb, gsb;
    logic [15:0] ml;
    int          pkt_rem, pkt_len, pk, dctr;
    int          nofit_seen, exact_seen, align_before_rst, rst_marks;

    function automatic logic [15:0] tb_adv(input logic [15:0] s);
        logic [15:0] v;
        v = s;
        for (int i = 0; i < 16; i++) v = {v[14:0], v[15] ^ v[4] ^ v[3] ^ v[2]};
        return v;
    endfunction

    function automatic int rem_pay(input int b, input int i);
        if (b == 0 && i == 0) return SB_PAY;
        return ((i < DATA_N) ? DATA_N - i : 0) + (BLKS - 1 - b) * DATA_N;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            if (n_fail <= 25)
                $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
        end
    endtask

    // driver: presents one slot and pushes the expected output item
    task automatic drive_slot(input int c);
        bit   mark, par, exp_ready, take;
        int   rem;
        exp_t e;
        mark = (mb == 0 && mi == 0);
        par  = (mi >= DATA_N);
        rem  = rem_pay(mb, mi);
        if (pkt_rem == 0) begin
            pk++;
            if (gsb == 3 && rem < 600 && rem > 0)      pkt_len = rem + 1;
            else if (gsb == 5 && rem < 600 && rem > 0) pkt_len = rem;
            else                                       pkt_len = 1 + ((pk * 37) % 300);
            pkt_rem = pkt_len;
        end
        in_first = (pkt_rem == pkt_len);
        in_len   = 12'(pkt_rem);
        in_char  = {pk[7:0], dctr[7:0]} ^ 16'h3C00;
        in_valid = ((c % 13) != 7) || (gsb == 5 && in_first);
        par_char = 16'hB000 ^ 16'(c * 7);
        exp_ready = !mark && !par && (!in_first || pkt_rem <= rem);
        take      = in_valid && exp_ready;
        if (!mark && !par && in_first && pkt_rem > rem) nofit_seen++;
        if (take && in_first && pkt_rem == rem)         exact_seen++;
        if (mark) begin
            e.sp = 1'b1; e.pa = 1'b0;
            if (msb == 32) begin
                e.ch = RSTM; ml = SEED; e.tag = "R5 R7"; rst_marks++;
            end else begin
                e.ch = ALIGN; e.tag = "R4 R5";
                if (rst_marks == 0) align_before_rst++;
            end
        end else if (par) begin
            e.ch = par_char; e.sp = 1'b0; e.pa = 1'b1; e.tag = "R3";
        end else begin
            e.ch = (take ? in_char : GAP) ^ ml; e.sp = 1'b0; e.pa = 1'b0;
            e.tag = take ? "R6 R11" : "R8";
            ml = tb_adv(ml);
        end
        if (c == 0) e.tag = "R1";
        exp_q.push_back(e);
        #1;
        check(in_ready == exp_ready, in_first ? "R9" : "R10", in_ready, exp_ready);
        check(slot_index == 9'(mi) && slot_block == 2'(mb), "R2",
              {slot_block, slot_index}, {mb[1:0], mi[8:0]});
        check(slot_parity == par, "R3", slot_parity, par);
        if (take) begin
            pkt_rem--;
            dctr++;
        end
        mi++;
        if (mi == BLK_CHARS) begin
            mi = 0;
            mb++;
            if (mb == BLKS) begin
                mb  = 0;
                msb = (msb == 32) ? 0 : msb + 1;
                gsb++;
            end
        end
    endtask

    // monitor: pops the item due one clock after its slot
    task automatic monitor_pop();
        exp_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        check(out_valid === 1'b1, e.tag, out_valid, 1);
        check(out_char === e.ch, e.tag, out_char, e.ch);
        check(out_special === e.sp && out_parity === e.pa, e.tag,
              {out_special, out_parity}, {e.sp, e.pa});
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; in_first = 0; in_len = '0; in_char = '0; par_char = '0;
        mb = 0; mi = 0; msb = 0; gsb = 0; ml = SEED;
        pkt_rem = 0; pkt_len = 0; pk = 0; dctr = 0;
        nofit_seen = 0; exact_seen = 0; align_before_rst = 0; rst_marks = 0;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        rst = 1'b0;
        for (int c = 0; c < RUN_CYC; c++) begin
            if (c > 0) begin
                @(negedge clk);
                monitor_pop();
            end
            drive_slot(c);
        end
        @(negedge clk);
        monitor_pop();
        check(align_before_rst == 32, "R5", align_before_rst, 32);
        check(rst_marks >= 1, "R5", rst_marks, 1);
        check(nofit_seen > 0, "R9", nofit_seen, 1);
        check(exact_seen > 0, "R9", exact_seen, 1);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule